// File: doc/BRIEF.md
# Test Access Port with Pin Sharing

This block is a serial test access port that lets an external host step a sixteen-state controller, load a three-bit instruction, and scan one of three data paths. The paths are a one-bit pass-through, an eight-bit debug word and a twelve-bit programming word. Each of the two wide paths has a parallel output that an Update-DR step loads. Inside the chip, a debug engine and a programming engine read these outputs.

The four test signals share four pins of a general-purpose port. An enable flag sits in the system clock domain and decides whether the pins belong to the test port or to the port logic. The flag comes up set after power-on reset, so the pins are ready for test traffic at once. When software clears the flag, the port logic gets all four pins back and the test controller sees its mode input held high. The test clock is taken straight from its pin and is never timed against anything else. Stopping that clock at 0 leaves every test register frozen.

Top module: `tap_pinshare`

## Requirements
- R1: The pin enable flag is 1 after `por_n` is low. It loads `en_d` at a rising `clk` edge when `en_we` is 1, and otherwise it keeps its value.
- R2: While the flag is 1, pin bit 0 carries TDO, bit 1 carries TMS, bit 2 carries TDI and bit 3 carries TCK. `pad_oe[3:1]` is 0 and `gp_in` reads 4'hF.
- R3: While the flag is 0, `pad_out` equals `gp_out`, `pad_oe` equals `gp_oe` and `gp_in` equals `pad_in`. The controller sees TMS and TDI as 1, so five TCK pin pulses put it in Test-Logic-Reset.
- R4: The controller follows the standard sixteen-state graph, with TMS sampled on rising TCK. A low `por_n` forces Test-Logic-Reset, and five rising TCK edges with TMS high reach it from any state.
- R5: `pad_oe[0]` is 1 only while the state is Shift-IR or Shift-DR, and it and the TDO bit change on falling TCK only. When `pad_oe[0]` is 0, `pad_out[0]` reads 1.
- R6: Every scan moves TDI into the MSB and presents the LSB on TDO, so data goes in and comes out LSB first.
- R7: Capture-IR loads 3'b001. The active instruction takes the shifted value in Update-IR and becomes 3'b111 in Test-Logic-Reset or on `por_n`.
- R8: Instruction 3'b000 selects the 12-bit programming register and 3'b010 selects the 8-bit debug register. Every other code selects the 1-bit bypass path, which captures 0.
- R9: Capture-DR loads the selected register's current parallel output, and Update-DR copies the shifted value to it. The parallel outputs `dbg_q` and `spr_q` are cleared only by `por_n`.
- R10: While TCK stays at 0, the controller state and all scan registers keep their values for any length of time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| por_n | input | 1 | Asynchronous power-on reset, active low |
| clk | input | 1 | System clock for the enable flag |
| en_we | input | 1 | Write strobe for the enable flag |
| en_d | input | 1 | New enable flag value |
| pad_in | input | 4 | Levels seen on the four shared pins |
| pad_out | output | 4 | Values driven to the pins |
| pad_oe | output | 4 | Output enables of the pins |
| gp_out | input | 4 | Port logic output values |
| gp_oe | input | 4 | Port logic output enables |
| gp_in | output | 4 | Pin levels returned to port logic |
| dbg_q | output | DBG_W | Parallel output of the debug register |
| spr_q | output | SPR_W | Parallel output of the programming register |

## Verification
The controller moves at the rising TCK edge, so a TDO bit or output enable shows up only after the falling edge that follows. The bench therefore samples 2 ns after each falling edge, and in one test it also samples in the high phase to show that the enable has not yet moved. A scan's first bit is valid after the pulse that enters the Shift state, and each later bit is valid after the pulse that shifts it in. The parallel outputs change at the rising edge taken in Update-DR, and the bench reads them only after the scan has gone back to Run-Test/Idle. A write to the enable flag takes effect at the next rising `clk` edge, and the pin multiplexer follows it with no further delay, so pin checks are made after the bench has waited out that `clk` edge.

// File: rtl/tap_pinshare_pkg.sv
package tap_pinshare_pkg;

   localparam int IR_W = 3;
   typedef logic [IR_W-1:0] instr_t;

   // instruction codes; any code not listed selects the bypass path
   localparam instr_t IR_SPR  = 3'b000;
   localparam instr_t IR_DBG  = 3'b010;
   localparam instr_t IR_BYP  = 3'b111;
   localparam instr_t IR_CAPT = 3'b001;

   // position of each test signal in the shared port
   localparam int PIN_TDO = 0;
   localparam int PIN_TMS = 1;
   localparam int PIN_TDI = 2;
   localparam int PIN_TCK = 3;
   localparam int NPIN    = 4;

   typedef enum logic [3:0] {
      S_TLR, S_RTI,
      S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PA_DR, S_EX2_DR, S_UPD_DR,
      S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PA_IR, S_EX2_IR, S_UPD_IR
   } tap_state_e;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import tap_pinshare_pkg::*;
(
   input  logic       tck,
   input  logic       por_n,
   input  logic       tms,
   output tap_state_e state
);

   tap_state_e nxt;

   always_comb begin
      unique case (state)
         S_TLR:    nxt = tms ? S_TLR    : S_RTI;
         S_RTI:    nxt = tms ? S_SEL_DR : S_RTI;
         S_SEL_DR: nxt = tms ? S_SEL_IR : S_CAP_DR;
         S_CAP_DR: nxt = tms ? S_EX1_DR : S_SH_DR;
         S_SH_DR:  nxt = tms ? S_EX1_DR : S_SH_DR;
         S_EX1_DR: nxt = tms ? S_UPD_DR : S_PA_DR;
         S_PA_DR:  nxt = tms ? S_EX2_DR : S_PA_DR;
         S_EX2_DR: nxt = tms ? S_UPD_DR : S_SH_DR;
         S_UPD_DR: nxt = tms ? S_SEL_DR : S_RTI;
         S_SEL_IR: nxt = tms ? S_TLR    : S_CAP_IR;
         S_CAP_IR: nxt = tms ? S_EX1_IR : S_SH_IR;
         S_SH_IR:  nxt = tms ? S_EX1_IR : S_SH_IR;
         S_EX1_IR: nxt = tms ? S_UPD_IR : S_PA_IR;
         S_PA_IR:  nxt = tms ? S_EX2_IR : S_PA_IR;
         S_EX2_IR: nxt = tms ? S_UPD_IR : S_SH_IR;
         S_UPD_IR: nxt = tms ? S_SEL_DR : S_RTI;
         default:  nxt = S_TLR;
      endcase
   end

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) state <= S_TLR;
      else        state <= nxt;
   end

   // run of consecutive TMS-high edges, saturating at five
   logic [2:0] hi_run;
   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)               hi_run <= 3'd0;
      else if (!tms)            hi_run <= 3'd0;
      else if (hi_run != 3'd5)  hi_run <= hi_run + 3'd1;
   end

   a_r4_five_high_reset: assert property (@(posedge tck) disable iff (!por_n)
      (hi_run == 3'd5) |-> (state == S_TLR));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
   import tap_pinshare_pkg::*;
(
   input  logic       tck,
   input  logic       por_n,
   input  tap_state_e state,
   input  logic       tdi,
   output instr_t     ir_q,
   output logic       ir_lsb
);

   instr_t ir_sr;

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) begin
         ir_sr <= IR_CAPT;
         ir_q  <= IR_BYP;
      end else begin
         if (state == S_CAP_IR)     ir_sr <= IR_CAPT;
         else if (state == S_SH_IR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};

         if (state == S_UPD_IR)     ir_q <= ir_sr;
         else if (state == S_TLR)   ir_q <= IR_BYP;
      end
   end

   assign ir_lsb = ir_sr[0];

   logic armed;
   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   a_r7_capture_pattern: assert property (@(posedge tck) disable iff (!por_n)
      (armed && $past(state) == S_CAP_IR) |-> (ir_sr == IR_CAPT));

   a_r7_update_only: assert property (@(posedge tck) disable iff (!por_n)
      (armed && ir_q != $past(ir_q)) |->
         ($past(state) == S_UPD_IR || $past(state) == S_TLR));

endmodule

// File: rtl/tap_dreg.sv
module tap_dreg #(
   parameter int W = 8
) (
   input  logic         tck,
   input  logic         por_n,
   input  logic         sel,
   input  logic         capture,
   input  logic         shift,
   input  logic         update,
   input  logic         tdi,
   output logic         sr_lsb,
   output logic [W-1:0] par_q
);

   logic [W-1:0] sr;
   logic [W-1:0] sr_shifted;

   generate
      if (W == 1) begin : g_one
         assign sr_shifted = tdi;
      end else begin : g_wide
         assign sr_shifted = {tdi, sr[W-1:1]};
      end
   endgenerate

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) begin
         sr    <= '0;
         par_q <= '0;
      end else if (sel) begin
         if (capture)    sr    <= par_q;
         else if (shift) sr    <= sr_shifted;
         if (update)     par_q <= sr;
      end
   end

   assign sr_lsb = sr[0];

   logic armed;
   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   a_r9_par_update_only: assert property (@(posedge tck) disable iff (!por_n)
      (armed && par_q != $past(par_q)) |-> $past(sel && update));

endmodule

// File: rtl/tap_dr_path.sv
module tap_dr_path
   import tap_pinshare_pkg::*;
#(
   parameter int DBG_W = 8,
   parameter int SPR_W = 12
) (
   input  logic             tck,
   input  logic             por_n,
   input  tap_state_e       state,
   input  instr_t           ir_q,
   input  logic             tdi,
   output logic             dr_lsb,
   output logic [DBG_W-1:0] dbg_q,
   output logic [SPR_W-1:0] spr_q
);

   logic sel_dbg, sel_spr, sel_byp;
   logic cap, shf, upd;
   logic dbg_lsb, spr_lsb, byp_ff;

   assign sel_dbg = (ir_q == IR_DBG);
   assign sel_spr = (ir_q == IR_SPR);
   assign sel_byp = !(sel_dbg || sel_spr);

   assign cap = (state == S_CAP_DR);
   assign shf = (state == S_SH_DR);
   assign upd = (state == S_UPD_DR);

   tap_dreg #(.W(DBG_W)) u_dbg (
      .tck(tck), .por_n(por_n), .sel(sel_dbg), .capture(cap), .shift(shf),
      .update(upd), .tdi(tdi), .sr_lsb(dbg_lsb), .par_q(dbg_q)
   );

   tap_dreg #(.W(SPR_W)) u_spr (
      .tck(tck), .por_n(por_n), .sel(sel_spr), .capture(cap), .shift(shf),
      .update(upd), .tdi(tdi), .sr_lsb(spr_lsb), .par_q(spr_q)
   );

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                byp_ff <= 1'b0;
      else if (sel_byp && cap)   byp_ff <= 1'b0;
      else if (sel_byp && shf)   byp_ff <= tdi;
   end

   always_comb begin
      if (sel_dbg)      dr_lsb = dbg_lsb;
      else if (sel_spr) dr_lsb = spr_lsb;
      else              dr_lsb = byp_ff;
   end

endmodule

// File: rtl/tap_pin_mux.sv
module tap_pin_mux
   import tap_pinshare_pkg::*;
(
   input  logic            tap_en,
   input  logic [NPIN-1:0] pad_in,
   input  logic [NPIN-1:0] gp_out,
   input  logic [NPIN-1:0] gp_oe,
   input  logic            tdo_val,
   input  logic            tdo_oe,
   output logic [NPIN-1:0] pad_out,
   output logic [NPIN-1:0] pad_oe,
   output logic [NPIN-1:0] gp_in,
   output logic            tms_i,
   output logic            tdi_i
);

   generate
      for (genvar i = 0; i < NPIN; i++) begin : g_pin
         if (i == PIN_TDO) begin : g_out
            assign pad_out[i] = tap_en ? (tdo_oe ? tdo_val : 1'b1) : gp_out[i];
            assign pad_oe[i]  = tap_en ? tdo_oe : gp_oe[i];
         end else begin : g_in
            assign pad_out[i] = tap_en ? 1'b1 : gp_out[i];
            assign pad_oe[i]  = tap_en ? 1'b0 : gp_oe[i];
         end
         assign gp_in[i] = tap_en ? 1'b1 : pad_in[i];
      end
   endgenerate

   // weak-high value when the port logic owns the pins
   assign tms_i = tap_en ? pad_in[PIN_TMS] : 1'b1;
   assign tdi_i = tap_en ? pad_in[PIN_TDI] : 1'b1;

endmodule

// File: rtl/tap_pinshare.sv
module tap_pinshare
   import tap_pinshare_pkg::*;
#(
   parameter int DBG_W = 8,
   parameter int SPR_W = 12
) (
   input  logic             por_n,
   input  logic             clk,
   input  logic             en_we,
   input  logic             en_d,
   input  logic [3:0]       pad_in,
   output logic [3:0]       pad_out,
   output logic [3:0]       pad_oe,
   input  logic [3:0]       gp_out,
   input  logic [3:0]       gp_oe,
   output logic [3:0]       gp_in,
   output logic [DBG_W-1:0] dbg_q,
   output logic [SPR_W-1:0] spr_q
);

   generate
      if (DBG_W < 1 || SPR_W < 1) begin : g_bad_width
         $error("data register widths must be at least one bit");
      end
      if (IR_DBG == IR_SPR || IR_DBG == IR_BYP || IR_SPR == IR_BYP) begin : g_bad_code
         $error("instruction codes must be distinct");
      end
      if (NPIN != 4) begin : g_bad_pins
         $error("the port shares exactly four pins");
      end
   endgenerate

   logic       tap_en;
   logic       tck_i, tms_i, tdi_i;
   tap_state_e state;
   instr_t     ir_q;
   logic       ir_lsb, dr_lsb;
   logic       tdo_q, tdo_oe_q;

   // pin ownership flag, set by power-on reset
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)     tap_en <= 1'b1;
      else if (en_we) tap_en <= en_d;
   end

   a_r1_flag_holds: assert property (@(posedge clk) disable iff (!por_n)
      !en_we |=> $stable(tap_en));

   assign tck_i = pad_in[PIN_TCK];

   tap_pin_mux u_mux (
      .tap_en(tap_en), .pad_in(pad_in), .gp_out(gp_out), .gp_oe(gp_oe),
      .tdo_val(tdo_q), .tdo_oe(tdo_oe_q), .pad_out(pad_out), .pad_oe(pad_oe),
      .gp_in(gp_in), .tms_i(tms_i), .tdi_i(tdi_i)
   );

   tap_fsm u_fsm (.tck(tck_i), .por_n(por_n), .tms(tms_i), .state(state));

   tap_ir u_ir (
      .tck(tck_i), .por_n(por_n), .state(state), .tdi(tdi_i),
      .ir_q(ir_q), .ir_lsb(ir_lsb)
   );

   tap_dr_path #(.DBG_W(DBG_W), .SPR_W(SPR_W)) u_dr (
      .tck(tck_i), .por_n(por_n), .state(state), .ir_q(ir_q), .tdi(tdi_i),
      .dr_lsb(dr_lsb), .dbg_q(dbg_q), .spr_q(spr_q)
   );

   // serial output retimed to the falling edge
   always_ff @(negedge tck_i or negedge por_n) begin
      if (!por_n) begin
         tdo_q    <= 1'b1;
         tdo_oe_q <= 1'b0;
      end else begin
         tdo_oe_q <= (state == S_SH_IR) || (state == S_SH_DR);
         tdo_q    <= (state == S_SH_IR) ? ir_lsb : dr_lsb;
      end
   end

   a_r5_tdo_only_shift: assert property (@(posedge tck_i) disable iff (!por_n)
      tdo_oe_q == ((state == S_SH_IR) || (state == S_SH_DR)));

endmodule

// File: tb/sim_tap_pinshare.sv
`timescale 1ns/1ps
module sim_tap_pinshare;

   logic        por_n, clk, en_we, en_d;
   logic [3:0]  pad_drv, gp_out, gp_oe;
   logic [3:0]  pad_out, pad_oe, gp_in;
   logic [7:0]  dbg_q;
   logic [11:0] spr_q;
   logic        tdo_s, oe_s;
   int          checks = 0, errors = 0;
   bit          done = 0;

   tap_pinshare #(.DBG_W(8), .SPR_W(12)) u0 (
      .por_n(por_n), .clk(clk), .en_we(en_we), .en_d(en_d), .pad_in(pad_drv),
      .pad_out(pad_out), .pad_oe(pad_oe), .gp_out(gp_out), .gp_oe(gp_oe),
      .gp_in(gp_in), .dbg_q(dbg_q), .spr_q(spr_q)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   // {ir, din, expected scan-out, expected dbg_q, expected spr_q}
   localparam logic [46:0] VEC [8] = '{
      {3'b010, 12'h0A5, 12'h000, 8'hA5, 12'h000},
      {3'b000, 12'h3C9, 12'h000, 8'hA5, 12'h3C9},
      {3'b010, 12'h05A, 12'h0A5, 8'h5A, 12'h3C9},
      {3'b000, 12'hFFF, 12'h3C9, 8'h5A, 12'hFFF},
      {3'b111, 12'h00B, 12'h006, 8'h5A, 12'hFFF},
      {3'b101, 12'h005, 12'h00A, 8'h5A, 12'hFFF},
      {3'b010, 12'h000, 12'h05A, 8'h00, 12'hFFF},
      {3'b011, 12'h003, 12'h006, 8'h00, 12'hFFF}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic pulse(input logic tms, input logic tdi);
      pad_drv[1] = tms;
      pad_drv[2] = tdi;
      #10 pad_drv[3] = 1'b1;
      #10 pad_drv[3] = 1'b0;
      #2  tdo_s = pad_out[0];
      oe_s = pad_oe[0];
      #8;
   endtask

   // from Run-Test/Idle, through Update, back to Run-Test/Idle
   task automatic scan(input bit is_ir, input int len, input logic [15:0] din,
                       output logic [15:0] dout);
      dout = '0;
      pulse(1'b1, 1'b0);
      if (is_ir) pulse(1'b1, 1'b0);
      pulse(1'b0, 1'b0);
      pulse(1'b0, 1'b0);
      dout[0] = tdo_s;
      for (int i = 0; i < len; i++) begin
         pulse(i == len - 1, din[i]);
         if (i < len - 1) dout[i+1] = tdo_s;
      end
      pulse(1'b1, 1'b0);
      pulse(1'b0, 1'b0);
   endtask

   function automatic int dr_len(input logic [2:0] code);
      if (code == 3'b000) return 12;
      if (code == 3'b010) return 8;
      return 4;
   endfunction

   task automatic write_en(input logic v);
      @(negedge clk);
      en_we = 1'b1; en_d = v;
      @(negedge clk);
      en_we = 1'b0;
      #2;
   endtask

   initial begin
      #3_000_000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] so;
      por_n = 1'b0; en_we = 1'b0; en_d = 1'b0;
      pad_drv = 4'b0110; gp_out = 4'b0000; gp_oe = 4'b0000;
      tdo_s = 1'b1; oe_s = 1'b0;
      #45 por_n = 1'b1;
      #10;

      // reset state
      check("R1 gp_in after reset", gp_in, 4'hF);
      check("R2 pad_oe after reset", pad_oe, 4'h0);
      check("R5 tdo weak high after reset", pad_out[0], 1'b1);
      check("R9 dbg_q reset", dbg_q, 8'h00);
      check("R9 spr_q reset", spr_q, 12'h000);

      pulse(1'b0, 1'b0);
      scan(1'b0, 4, 16'h000B, so);
      check("R7 bypass after reset", so, 16'h0006);

      // vector table
      for (int v = 0; v < 8; v++) begin
         logic [2:0]  code;
         logic [11:0] din, dout, espr;
         logic [7:0]  edbg;
         {code, din, dout, edbg, espr} = VEC[v];
         scan(1'b1, 3, {13'd0, code}, so);
         check("R7 capture-IR pattern", so, 16'h0001);
         scan(1'b0, dr_len(code), {4'd0, din}, so);
         check("R6 R8 scan out", so, {4'd0, dout});
         check("R9 dbg_q", dbg_q, edbg);
         check("R9 spr_q", spr_q, espr);
      end

      // five TMS-high edges from Pause-DR
      scan(1'b1, 3, 16'h0002, so);
      pulse(1'b1, 1'b0); pulse(1'b0, 1'b0); pulse(1'b1, 1'b0); pulse(1'b0, 1'b0);
      check("R5 no drive in Pause-DR", {pad_oe[0], pad_out[0]}, 2'b01);
      for (int k = 0; k < 5; k++) pulse(1'b1, 1'b0);
      pulse(1'b0, 1'b0);
      scan(1'b0, 4, 16'h000B, so);
      check("R4 five highs reset the instruction", so, 16'h0006);

      // TCK held low in the middle of a scan
      scan(1'b1, 3, 16'h0002, so);
      pulse(1'b1, 1'b0); pulse(1'b0, 1'b0); pulse(1'b0, 1'b0);
      so = '0;
      so[0] = tdo_s;
      for (int i = 0; i < 4; i++) begin pulse(1'b0, (8'hC3 >> i) & 1'b1); so[i+1] = tdo_s; end
      #4000;
      for (int i = 4; i < 8; i++) begin
         pulse(i == 7, (8'hC3 >> i) & 1'b1);
         if (i < 7) so[i+1] = tdo_s;
      end
      pulse(1'b1, 1'b0); pulse(1'b0, 1'b0);
      check("R10 scan across stopped clock", so, 16'h0000);
      check("R10 update after stopped clock", dbg_q, 8'hC3);

      // falling-edge timing of the output enable
      pulse(1'b1, 1'b0); pulse(1'b0, 1'b0);
      check("R5 no drive in Capture-DR", oe_s, 1'b0);
      pad_drv[1] = 1'b0;
      #10 pad_drv[3] = 1'b1;
      #5  check("R5 enable waits for falling edge", pad_oe[0], 1'b0);
      #5  pad_drv[3] = 1'b0;
      #2  check("R5 enable after falling edge", pad_oe[0], 1'b1);
      #8;
      pulse(1'b1, 1'b0);
      check("R5 released in Exit1-DR", {oe_s, tdo_s}, 2'b01);
      pulse(1'b1, 1'b0); pulse(1'b0, 1'b0);

      // pins handed to the port logic
      scan(1'b1, 3, 16'h0002, so);
      write_en(1'b0);
      gp_out = 4'b1010; gp_oe = 4'b0110; pad_drv = 4'b0101;
      #2;
      check("R3 pad_out follows port", pad_out, 4'b1010);
      check("R3 pad_oe follows port", pad_oe, 4'b0110);
      check("R3 gp_in follows pins", gp_in, 4'b0101);
      pad_drv[1] = 1'b0;
      for (int k = 0; k < 5; k++) begin #10 pad_drv[3] = 1'b1; #10 pad_drv[3] = 1'b0; end
      write_en(1'b1);
      check("R1 flag written back", gp_in, 4'hF);
      check("R2 pins back to test port", pad_oe, 4'h0);
      pulse(1'b0, 1'b0);
      scan(1'b0, 4, 16'h000B, so);
      check("R3 controller reset while disabled", so, 16'h0006);

      // power-on reset returns the pins
      write_en(1'b0);
      check("R1 flag cleared", gp_in, pad_drv);
      por_n = 1'b0;
      #30 por_n = 1'b1;
      #2;
      check("R1 reset restores test port", gp_in, 4'hF);
      check("R9 dbg_q cleared by reset", dbg_q, 8'h00);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule